// File: doc/BRIEF.md
# Synchronized Clock-Stop Controller

This block sits between the clock synthesizers and the clock output drivers of a system clock generator. It gates a group of CPU-rate clocks and a group of PCI-rate clocks for power management. It also passes one PCI-rate clock that is exempt from the PCI stop request, and it raises a flag that tells the oscillator and PLLs to shut down. There are three request inputs: an active-low CPU stop, an active-low PCI stop and an active-low power-down. All three may change at any time relative to the clocks. Each request is synchronized into the clock domain it controls. Every gate enable is updated on the falling edge of its own clock, so a gated output only starts or stops at a whole-cycle boundary and always parks LOW.

A strap input decides whether the two stop pins are in use. When the strap is HIGH, those pins carry memory clock outputs elsewhere on the chip, so this block ignores them. Power sequencing is handled by a three-state machine clocked by the CPU-rate clock:
- `PM_OFF` flags the oscillator off and holds every output LOW.
- `PM_SETTLE` releases the oscillator and counts `SETTLE_CYCLES` CPU cycles. This count stands in for PLL lock.
- `PM_RUN` lets the clocks through.

The transitions are:
- `PM_OFF -> PM_SETTLE` when the synchronized power request is released.
- `PM_SETTLE -> PM_RUN` when the count expires.
- `PM_SETTLE -> PM_OFF` and `PM_RUN -> PM_OFF` whenever power-down is requested again.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is LOW, `osc_off_o` is 1 and every clock output (`cpu_clk_o`, `pci_clk_o`, `pci_free_o`) is LOW.
- R2: With `strap_mode`=0 and `cpu_stop_n`=0 (0 means stop), every bit of `cpu_clk_o` stays LOW, while `pci_clk_o` and `pci_free_o` keep toggling.
- R3: Suppose `cpu_stop_n` (or `strap_mode` while a CPU stop is held) changes during a LOW phase of `clk_cpu`. The first two rising `clk_cpu` edges after the change still produce the old output state. From the third rising edge on, `cpu_clk_o` follows the new state, whether stopping or restarting.
- R4: With `strap_mode`=0 and `pci_stop_n`=0, every bit of `pci_clk_o` stays LOW. In the same condition `pci_free_o` and `cpu_clk_o` keep toggling.
- R5: Suppose `pci_stop_n` changes during a LOW phase of `clk_pci`. The first rising `clk_pci` edge after the change still produces the old state of `pci_clk_o`. From the second rising edge on, `pci_clk_o` follows the new state.
- R6: While `strap_mode`=1, both stop inputs have no effect and all clock outputs keep toggling.
- R7: A gated output never shows a partial pulse. Each HIGH pulse covers a whole HIGH phase of its source clock.
- R8: After `pwr_dn_n` falls (0 means power down), `osc_off_o` becomes 1 on the third rising `clk_cpu` edge. Within 8 further CPU cycles, `cpu_clk_o`, `pci_clk_o` and `pci_free_o` are all held LOW.
- R9: After `pwr_dn_n` rises (or reset is released with `pwr_dn_n`=1), `osc_off_o` becomes 0 on the third rising `clk_cpu` edge, which enters `PM_SETTLE`. All outputs stay LOW through the next `SETTLE_CYCLES` rising CPU edges. `cpu_clk_o` pulses from the edge after that, and the PCI outputs run within 8 more CPU cycles.
- R10: A power-down request during `PM_SETTLE` returns to `PM_OFF` (`osc_off_o`=1) without any output pulse. The next wake-up counts the full `SETTLE_CYCLES` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Running CPU-rate clock from the synthesizer |
| clk_pci | input | 1 | Running PCI-rate clock, rising edges aligned with `clk_cpu` |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mode | input | 1 | 0: stop inputs honoured; 1: stop inputs ignored |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU clock stop request |
| pci_stop_n | input | 1 | Asynchronous active-low PCI clock stop request |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down request |
| cpu_clk_o | output | N_CPU | Gated CPU-rate clocks |
| pci_clk_o | output | N_PCI | Gated PCI-rate clocks |
| pci_free_o | output | 1 | PCI-rate clock gated only by power-down |
| osc_off_o | output | 1 | 1 requests oscillator and PLL shutdown |

## Verification
A corrupted power state shows on `osc_off_o` within one CPU cycle of the faulty transition. It shows on the CPU outputs one falling edge later, and on the PCI outputs within about three PCI periods. An early exit from `PM_SETTLE` produces CPU pulses while the settle window is still open, and the bench counts every edge of that window. A synchronizer chain that is too long or too short shifts the first stopped or restarted pulse by one edge, and the bench samples each edge around a request change. A gate enable that moves during a HIGH phase makes the output differ between the early and late parts of that phase, and a continuous monitor compares the two.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;
    typedef enum logic [1:0] {
        PM_OFF    = 2'd0,
        PM_SETTLE = 2'd1,
        PM_RUN    = 2'd2
    } pm_state_e;
endpackage

// File: rtl/csc_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer, all stages on the rising edge.
module csc_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/csc_gate.sv
`timescale 1ns/1ps
// Gate whose enable moves only on the falling edge of its clock,
// so a pulse is either passed whole or suppressed whole.
module csc_gate #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_req,
    output logic [W-1:0] gclk_o
);
    logic en_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_req;
    end

    for (genvar i = 0; i < W; i++) begin : g_fan
        assign gclk_o[i] = clk & en_q;
    end
endmodule

// File: rtl/csc_pwr_fsm.sv
`timescale 1ns/1ps
// Power sequencer: off -> settle (lock stand-in) -> run.
module csc_pwr_fsm
    import csc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    output logic osc_off_o,
    output logic run_o
);
    localparam int            CW   = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    pm_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_OFF:    if (pwr_ok) state_d = PM_SETTLE;
            PM_SETTLE: begin
                if (!pwr_ok)            state_d = PM_OFF;
                else if (cnt_q == LAST) state_d = PM_RUN;
            end
            PM_RUN:    if (!pwr_ok) state_d = PM_OFF;
            default:   state_d = PM_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (state_q != PM_SETTLE) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        unique case (state_q)
            PM_OFF:    begin osc_off_o = 1'b1; run_o = 1'b0; end
            PM_SETTLE: begin osc_off_o = 1'b0; run_o = 1'b0; end
            PM_RUN:    begin osc_off_o = 1'b0; run_o = 1'b1; end
            default:   begin osc_off_o = 1'b1; run_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl #(
    parameter int N_CPU           = 4,
    parameter int N_PCI           = 6,
    parameter int CPU_SYNC_STAGES = 2,
    parameter int PCI_SYNC_STAGES = 1,
    parameter int PWR_SYNC_STAGES = 2,
    parameter int XFER_STAGES     = 2,
    parameter int SETTLE_CYCLES   = 64
) (
    input  logic             clk_cpu,
    input  logic             clk_pci,
    input  logic             rst_n,
    input  logic             strap_mode,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_dn_n,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pci_free_o,
    output logic             osc_off_o
);
    localparam logic [1:0] REQ_IDLE = 2'b11;

    // ---------------- CPU domain ----------------
    logic pwr_ok_c;
    logic cpu_stop_n_s, mode_c_s;
    logic run_cpu, cpu_hold;

    csc_sync #(.W(1), .STAGES(PWR_SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
        .clk(clk_cpu), .rst_n(rst_n), .d(pwr_dn_n), .q(pwr_ok_c)
    );

    csc_sync #(.W(2), .STAGES(CPU_SYNC_STAGES), .RST_VAL(REQ_IDLE)) u_cpu_req_sync (
        .clk(clk_cpu), .rst_n(rst_n), .d({cpu_stop_n, strap_mode}),
        .q({cpu_stop_n_s, mode_c_s})
    );

    csc_pwr_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk(clk_cpu), .rst_n(rst_n), .pwr_ok(pwr_ok_c),
        .osc_off_o(osc_off_o), .run_o(run_cpu)
    );

    assign cpu_hold = !cpu_stop_n_s && !mode_c_s;

    csc_gate #(.W(N_CPU)) u_cpu_gate (
        .clk(clk_cpu), .rst_n(rst_n), .en_req(run_cpu && !cpu_hold),
        .gclk_o(cpu_clk_o)
    );

    // ---------------- PCI domain ----------------
    logic run_pci, pci_stop_n_s, mode_p_s, pci_hold;
    logic [0:0] free_vec;

    csc_sync #(.W(1), .STAGES(XFER_STAGES), .RST_VAL(1'b0)) u_run_xfer (
        .clk(clk_pci), .rst_n(rst_n), .d(run_cpu), .q(run_pci)
    );

    csc_sync #(.W(2), .STAGES(PCI_SYNC_STAGES), .RST_VAL(REQ_IDLE)) u_pci_req_sync (
        .clk(clk_pci), .rst_n(rst_n), .d({pci_stop_n, strap_mode}),
        .q({pci_stop_n_s, mode_p_s})
    );

    assign pci_hold = !pci_stop_n_s && !mode_p_s;

    csc_gate #(.W(N_PCI)) u_pci_gate (
        .clk(clk_pci), .rst_n(rst_n), .en_req(run_pci && !pci_hold),
        .gclk_o(pci_clk_o)
    );

    csc_gate #(.W(1)) u_free_gate (
        .clk(clk_pci), .rst_n(rst_n), .en_req(run_pci), .gclk_o(free_vec)
    );

    assign pci_free_o = free_vec[0];
endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk #(
    parameter int N_CPU         = 4,
    parameter int N_PCI         = 6,
    parameter int SETTLE_CYCLES = 64
) (
    input logic             clk_cpu,
    input logic             clk_pci,
    input logic             rst_n,
    input logic [N_CPU-1:0] cpu_clk_o,
    input logic [N_PCI-1:0] pci_clk_o,
    input logic             pci_free_o,
    input logic             osc_off_o
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    logic [3:0]    off_cnt;
    logic [CW-1:0] on_cnt;
    logic          all_low;

    assign all_low = (cpu_clk_o == '0) && (pci_clk_o == '0) && !pci_free_o;

    always_ff @(posedge clk_cpu or negedge rst_n) begin
        if (!rst_n) begin
            off_cnt <= '0;
            on_cnt  <= '0;
        end else if (osc_off_o) begin
            on_cnt <= '0;
            if (off_cnt != 4'hF) off_cnt <= off_cnt + 1'b1;
        end else begin
            off_cnt <= '0;
            if (on_cnt != CW'(SETTLE_CYCLES)) on_cnt <= on_cnt + 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(negedge clk_cpu)
        !rst_n |-> (osc_off_o && all_low));

    a_r2_cpu_uniform: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        (cpu_clk_o == '0) || (cpu_clk_o == '1));

    a_r4_gated_within_free: assert property (@(negedge clk_pci) disable iff (!rst_n)
        ((pci_clk_o & ~{N_PCI{pci_free_o}}) == '0));

    a_r8_off_all_low: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        (off_cnt >= 4'd8) |-> all_low);

    a_r9_settle_low: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        (!osc_off_o && (on_cnt < CW'(SETTLE_CYCLES))) |-> all_low);
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
    .N_CPU(N_CPU), .N_PCI(N_PCI), .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
    .clk_cpu(clk_cpu), .clk_pci(clk_pci), .rst_n(rst_n),
    .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o),
    .pci_free_o(pci_free_o), .osc_off_o(osc_off_o)
);

// File: tb/clkstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb_top;
    localparam int NC     = 4;
    localparam int NP     = 6;
    localparam int SETTLE = 64;
    localparam logic [NC-1:0] CPU_ALL = '1;
    localparam logic [NP-1:0] PCI_ALL = '1;

    logic clk_cpu, clk_pci, rst_n;
    logic strap_mode, cpu_stop_n, pci_stop_n, pwr_dn_n;
    logic [NC-1:0] cpu_clk_o;
    logic [NP-1:0] pci_clk_o;
    logic pci_free_o, osc_off_o;

    int n_chk = 0, n_fail = 0, runt_cnt = 0;
    bit mon_on = 0, done = 0;

    clkstop_ctrl #(.N_CPU(NC), .N_PCI(NP), .SETTLE_CYCLES(SETTLE)) dut_i (
        .clk_cpu(clk_cpu), .clk_pci(clk_pci), .rst_n(rst_n),
        .strap_mode(strap_mode), .cpu_stop_n(cpu_stop_n),
        .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
        .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o),
        .pci_free_o(pci_free_o), .osc_off_o(osc_off_o)
    );

    // 50 MHz CPU-rate clock, PCI-rate at half, rising edges aligned
    initial begin clk_cpu = 0; forever #10 clk_cpu = ~clk_cpu; end
    initial begin
        clk_pci = 0; #10;
        forever begin clk_pci = 1; #20; clk_pci = 0; #20; end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cpu_lo(); @(negedge clk_cpu); #1; endtask
    task automatic cpu_hi(); @(posedge clk_cpu); #2; endtask
    task automatic pci_lo(); @(negedge clk_pci); #1; endtask
    task automatic pci_hi(); @(posedge clk_pci); #2; endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // R7 monitors: output must agree early and late in each HIGH phase
    initial begin
        logic [NC-1:0] a;
        forever begin
            @(posedge clk_cpu); #1; a = cpu_clk_o; #8;
            if (mon_on && a !== cpu_clk_o) runt_cnt++;
        end
    end
    initial begin
        logic [NP:0] a;
        forever begin
            @(posedge clk_pci); #1; a = {pci_free_o, pci_clk_o}; #18;
            if (mon_on && a !== {pci_free_o, pci_clk_o}) runt_cnt++;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL WATCHDOG: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    // called right after a power request release in a CPU LOW phase (R9)
    task automatic t_wake();
        int hi = 0;
        cpu_hi(); check("R9 osc still off edge1", osc_off_o, 1);
        cpu_hi(); check("R9 osc still off edge2", osc_off_o, 1);
        cpu_hi(); check("R9 osc on edge3", osc_off_o, 0);
        for (int k = 0; k < SETTLE; k++) begin
            cpu_hi();
            if (cpu_clk_o != 0 || pci_clk_o != 0 || pci_free_o) hi++;
        end
        check("R9 low during settle", hi, 0);
        cpu_hi(); check("R9 cpu running after settle", cpu_clk_o, CPU_ALL);
        repeat (8) cpu_hi();
        pci_hi();
        check("R9 pci running", pci_clk_o, PCI_ALL);
        check("R9 free running", pci_free_o, 1);
    endtask

    task automatic t_reset();
        rst_n = 1; strap_mode = 0; cpu_stop_n = 1; pci_stop_n = 1; pwr_dn_n = 1;
        #1 rst_n = 0;
        repeat (3) begin
            cpu_hi();
            check("R1 osc off in reset", osc_off_o, 1);
            check("R1 cpu low in reset", cpu_clk_o, 0);
        end
        pci_hi();
        check("R1 pci low in reset", pci_clk_o, 0);
        check("R1 free low in reset", pci_free_o, 0);
        cpu_lo(); rst_n = 1; mon_on = 1;
        t_wake();
    endtask

    task automatic t_cpu_stop();
        cpu_lo(); cpu_stop_n = 0;
        for (int k = 0; k < 5; k++) begin
            cpu_hi(); check("R3 stop latency", cpu_clk_o, (k < 2) ? CPU_ALL : '0);
        end
        pci_hi();
        check("R2 cpu held low", cpu_clk_o, 0);
        check("R2 pci unaffected", pci_clk_o, PCI_ALL);
        check("R2 free unaffected", pci_free_o, 1);
        cpu_lo(); cpu_stop_n = 1;
        for (int k = 0; k < 5; k++) begin
            cpu_hi(); check("R3 restart latency", cpu_clk_o, (k < 2) ? '0 : CPU_ALL);
        end
    endtask

    task automatic t_pci_stop();
        pci_lo(); pci_stop_n = 0;
        for (int k = 0; k < 3; k++) begin
            pci_hi();
            check("R5 stop latency", pci_clk_o, (k < 1) ? PCI_ALL : '0);
            check("R4 free keeps running", pci_free_o, 1);
        end
        check("R4 cpu unaffected", cpu_clk_o, CPU_ALL);
        pci_lo(); pci_stop_n = 1;
        for (int k = 0; k < 3; k++) begin
            pci_hi(); check("R5 restart latency", pci_clk_o, (k < 1) ? '0 : PCI_ALL);
        end
    endtask

    task automatic t_mode();
        cpu_lo(); strap_mode = 1;
        repeat (4) cpu_hi();
        cpu_lo(); cpu_stop_n = 0; pci_stop_n = 0;
        repeat (6) cpu_hi();
        check("R6 cpu ignores stop", cpu_clk_o, CPU_ALL);
        pci_hi();
        check("R6 pci ignores stop", pci_clk_o, PCI_ALL);
        cpu_lo(); strap_mode = 0;
        for (int k = 0; k < 3; k++) begin
            cpu_hi(); check("R3 strap release latency", cpu_clk_o, (k < 2) ? CPU_ALL : '0);
        end
        pci_hi(); pci_hi();
        check("R4 pci stopped after strap low", pci_clk_o, 0);
        cpu_lo(); cpu_stop_n = 1; pci_stop_n = 1;
        repeat (6) cpu_hi();
        pci_hi();
        check("R6 restore cpu", cpu_clk_o, CPU_ALL);
        check("R6 restore pci", pci_clk_o, PCI_ALL);
    endtask

    task automatic t_pwr_down();
        cpu_lo(); pwr_dn_n = 0;
        cpu_hi(); check("R8 osc on edge1", osc_off_o, 0);
        cpu_hi(); check("R8 osc on edge2", osc_off_o, 0);
        cpu_hi(); check("R8 osc off edge3", osc_off_o, 1);
        repeat (8) cpu_hi();
        for (int k = 0; k < 3; k++) begin
            cpu_hi(); check("R8 cpu low", cpu_clk_o, 0);
            pci_hi();
            check("R8 pci low", pci_clk_o, 0);
            check("R8 free low", pci_free_o, 0);
        end
    endtask

    task automatic t_abort();
        int hi = 0;
        cpu_lo(); pwr_dn_n = 1;
        repeat (3) cpu_hi();
        check("R10 settle entered", osc_off_o, 0);
        repeat (10) begin cpu_hi(); if (cpu_clk_o != 0 || pci_free_o) hi++; end
        cpu_lo(); pwr_dn_n = 0;
        repeat (3) cpu_hi();
        check("R10 back to off", osc_off_o, 1);
        repeat (SETTLE + 4) begin cpu_hi(); if (cpu_clk_o != 0 || pci_free_o) hi++; end
        check("R10 no pulse on abort", hi, 0);
        check("R10 stays off", osc_off_o, 1);
        cpu_lo(); pwr_dn_n = 1;
        t_wake();
    endtask

    initial begin
        t_reset();
        t_cpu_stop();
        t_pci_stop();
        t_mode();
        t_pwr_down();
        t_abort();
        repeat (4) cpu_hi();
        check("R7 whole pulses only", runt_cnt, 0);
        done = 1;
        summary();
        $finish;
    end
endmodule